// File: doc/BRIEF.md
# I2C Slave Address Matcher with Window Range

This block decides whether an address heard on the I2C bus selects the local slave. When the receive logic finishes an address, it raises a one-cycle strobe and presents the address together with a flag that says whether it was a 7-bit or a 10-bit address. The matcher always compares that address exactly against the programmed own address. When window mode is enabled, it also accepts any address inside a window. The window's lower edge is the own address, which is excluded. Its upper edge is a second bound register, which is included.

The own-address and bound registers are 8 bits wide. A separate 3-bit high field supplies address bits 10:8 when extended addressing is enabled. When extended addressing is off, that field is taken as zero. For a 7-bit address, only bits 6:0 of the received address and of both registers take part.

One clock after the strobe, the block emits a single-cycle match pulse and a kind code that tells the exact path from the window path. The strobe is a plain valid with no ready, so the block never applies back-pressure: a new address may be offered on every cycle, and each one gets its own result one cycle later. Configuration inputs are sampled in the strobe cycle.

Top module: `i2c_range_match`

## Requirements
- R1: After reset, and until the first strobe has been evaluated, `match_pulse` is 0 and `match_kind` is 0 (none).
- R2: When a strobed address equals the effective own address, the result is a match with kind 1 (exact). This holds whether window mode is on or off.
- R3: With `cfg_range_en`=1, a strobed address strictly above the effective own address and at or below the effective bound gives a match with kind 2 (window).
- R4: The lower window edge is exclusive: an address equal to the own address reports kind 1, never 2. An address below the own address produces no match unless it hits exactly.
- R5: The upper window edge is inclusive: an address equal to the bound matches with kind 2, and the address one above the bound gives no window match.
- R6: With `cfg_range_en`=0, no address inside the window produces a match other than an exact hit.
- R7: When the effective bound is less than or equal to the effective own address, the window is empty and kind 2 never occurs.
- R8: For a 7-bit address (`rx_is_10b`=0), bit 7 of both registers, the high field, and received bits 10:7 have no effect on the result.
- R9: For a 10-bit address, the effective own address is {hi, own[7:0]} and the effective bound is {hi, bound[7:0]}, where hi is `cfg_ext_hi` when `cfg_ext_en`=1 and 0 otherwise.
- R10: `match_pulse` is high for exactly the one cycle after a matching strobe and low otherwise. `match_kind` is 0 whenever `match_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid | input | 1 | Address-complete strobe, one cycle per address |
| rx_is_10b | input | 1 | Received address is 10-bit (1) or 7-bit (0) |
| rx_addr | input | 11 | Received address, right-aligned |
| cfg_own_addr | input | 8 | Own address, low 8 bits |
| cfg_range_bound | input | 8 | Window upper bound, low 8 bits |
| cfg_ext_hi | input | 3 | Address bits 10:8 for extended addressing |
| cfg_ext_en | input | 1 | Extended addressing enable; high field is ignored when 0 |
| cfg_range_en | input | 1 | Window matching enable |
| match_pulse | output | 1 | One-cycle match indication, one cycle after the strobe |
| match_kind | output | 2 | 0 none, 1 exact, 2 window; valid with `match_pulse` |

## Verification
Directed cases put the address at own-1, own, own+1, bound and bound+1. These separate the exclusive lower edge from the inclusive upper edge, and the exact path from the window path. Further directed cases use an inverted window (bound below own) and a bound equal to own to show the empty-window rule. Other cases toggle bit 7 and the high field in 7-bit mode, and toggle the extended enable in 10-bit mode, to show which register bits count. Randomly drawn addresses biased toward the window edges, with random enables, are then compared against a bench model; back-to-back strobes and idle cycles check the pulse shape.

// File: rtl/i2c_rm_pkg.sv
package i2c_rm_pkg;
  localparam int LO_W    = 8;
  localparam int HI_W    = 3;
  localparam int SHORT_W = 7;
  localparam int FULL_W  = LO_W + HI_W;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_EXACT = 2'd1,
    KIND_RANGE = 2'd2
  } match_kind_e;
endpackage

// File: rtl/i2c_rm_addr_form.sv
module i2c_rm_addr_form #(
  parameter int LO_W    = 8,
  parameter int HI_W    = 3,
  parameter int SHORT_W = 7,
  localparam int FULL_W = LO_W + HI_W
) (
  input  logic              is_10b,
  input  logic              ext_en,
  input  logic [HI_W-1:0]   ext_hi,
  input  logic [LO_W-1:0]   own_lo,
  input  logic [LO_W-1:0]   bound_lo,
  input  logic [FULL_W-1:0] rx_in,
  output logic [FULL_W-1:0] own_eff,
  output logic [FULL_W-1:0] bound_eff,
  output logic [FULL_W-1:0] rx_eff
);
  logic [HI_W-1:0]   hi_eff;
  logic [FULL_W-1:0] own_wide;
  logic [FULL_W-1:0] bound_wide;
  logic [FULL_W-1:0] keep;

  assign hi_eff     = ext_en ? ext_hi : '0;
  assign own_wide   = {hi_eff, own_lo};
  assign bound_wide = {hi_eff, bound_lo};

  // Per-bit keep mask: short addresses keep the low SHORT_W bits only.
  for (genvar b = 0; b < FULL_W; b++) begin : g_keep
    if (b < SHORT_W) begin : g_always
      assign keep[b] = 1'b1;
    end else begin : g_long
      assign keep[b] = is_10b;
    end
  end

  assign own_eff   = own_wide & keep;
  assign bound_eff = bound_wide & keep;
  assign rx_eff    = rx_in & keep;
endmodule

// File: rtl/i2c_rm_window.sv
module i2c_rm_window #(
  parameter int W = 11
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] lower,
  input  logic [W-1:0] upper,
  input  logic         win_en,
  output logic         hit_exact,
  output logic         hit_range
);
  logic above_lower;
  logic within_upper;

  assign hit_exact    = (addr == lower);
  assign above_lower  = (addr > lower);
  assign within_upper = (addr <= upper);
  assign hit_range    = win_en & above_lower & within_upper;
endmodule

// File: rtl/i2c_range_match.sv
module i2c_range_match
  import i2c_rm_pkg::*;
#(
  parameter int LO_W    = i2c_rm_pkg::LO_W,
  parameter int HI_W    = i2c_rm_pkg::HI_W,
  parameter int SHORT_W = i2c_rm_pkg::SHORT_W,
  localparam int FULL_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  input  logic              rx_is_10b,
  input  logic [FULL_W-1:0] rx_addr,
  input  logic [LO_W-1:0]   cfg_own_addr,
  input  logic [LO_W-1:0]   cfg_range_bound,
  input  logic [HI_W-1:0]   cfg_ext_hi,
  input  logic              cfg_ext_en,
  input  logic              cfg_range_en,
  output logic              match_pulse,
  output logic [1:0]        match_kind
);
  logic [FULL_W-1:0] own_eff;
  logic [FULL_W-1:0] bound_eff;
  logic [FULL_W-1:0] rx_eff;
  logic              hit_exact;
  logic              hit_range;
  match_kind_e       kind_d;
  match_kind_e       kind_q;
  logic              pulse_q;

  i2c_rm_addr_form #(
    .LO_W(LO_W), .HI_W(HI_W), .SHORT_W(SHORT_W)
  ) u_form (
    .is_10b   (rx_is_10b),
    .ext_en   (cfg_ext_en),
    .ext_hi   (cfg_ext_hi),
    .own_lo   (cfg_own_addr),
    .bound_lo (cfg_range_bound),
    .rx_in    (rx_addr),
    .own_eff  (own_eff),
    .bound_eff(bound_eff),
    .rx_eff   (rx_eff)
  );

  i2c_rm_window #(.W(FULL_W)) u_win (
    .addr     (rx_eff),
    .lower    (own_eff),
    .upper    (bound_eff),
    .win_en   (cfg_range_en),
    .hit_exact(hit_exact),
    .hit_range(hit_range)
  );

  always_comb begin
    kind_d = KIND_NONE;
    if (addr_valid) begin
      if (hit_exact)      kind_d = KIND_EXACT;
      else if (hit_range) kind_d = KIND_RANGE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      kind_q  <= KIND_NONE;
    end else begin
      pulse_q <= (kind_d != KIND_NONE);
      kind_q  <= kind_d;
    end
  end

  assign match_pulse = pulse_q;
  assign match_kind  = kind_q;

  // R10: a pulse only follows a strobe
  a_r10_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(addr_valid));
  // R10: kind is none without a pulse
  a_r10_kind_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !match_pulse |-> (match_kind == 2'd0));
  // R6: window kind only when the window was enabled
  a_r6_range_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (match_kind == 2'd2) |-> $past(cfg_range_en));
  // R7: window kind only when the window was non-empty
  a_r7_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
    (match_kind == 2'd2) |-> $past(bound_eff > own_eff));
  // R4: lower edge exclusive, the window path never fires on the own address
  a_r4_lower_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    hit_exact |-> !hit_range);
  // R5: a strobe at the bound with a valid window yields a pulse
  a_r5_upper_inclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && cfg_range_en && rx_eff == bound_eff && bound_eff > own_eff)
      |=> (match_pulse && match_kind == 2'd2));
endmodule

// File: tb/i2c_range_match_tb_top.sv
module i2c_range_match_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_valid = 1'b0;
  logic        rx_is_10b = 1'b0;
  logic [10:0] rx_addr = '0;
  logic [7:0]  cfg_own_addr = '0;
  logic [7:0]  cfg_range_bound = '0;
  logic [2:0]  cfg_ext_hi = '0;
  logic        cfg_ext_en = 1'b0;
  logic        cfg_range_en = 1'b0;
  logic        match_pulse;
  logic [1:0]  match_kind;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_range_match dut_i (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .rx_is_10b(rx_is_10b),
    .rx_addr(rx_addr), .cfg_own_addr(cfg_own_addr), .cfg_range_bound(cfg_range_bound),
    .cfg_ext_hi(cfg_ext_hi), .cfg_ext_en(cfg_ext_en), .cfg_range_en(cfg_range_en),
    .match_pulse(match_pulse), .match_kind(match_kind)
  );

  // Model from R2..R9: 0 none, 1 exact, 2 window
  function automatic logic [1:0] model_kind(
    input logic is10, input logic ext, input logic ren,
    input logic [7:0] own, input logic [7:0] bnd, input logic [2:0] hi,
    input logic [10:0] rx);
    int unsigned a, o, b;
    logic [2:0] h;
    h = ext ? hi : 3'd0;
    if (is10) begin
      a = rx; o = {h, own}; b = {h, bnd};
    end else begin
      a = rx[6:0]; o = own[6:0]; b = bnd[6:0];
    end
    if (a == o) return 2'd1;
    if (ren && a > o && a <= b) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(input string req, input logic [1:0] got_k, input logic got_p,
                       input logic [1:0] exp_k);
    logic exp_p;
    exp_p = (exp_k != 2'd0);
    checks++;
    if (got_k !== exp_k || got_p !== exp_p) begin
      errors++;
      $display("FAIL %s: pulse=%0b kind=%0d expected pulse=%0b kind=%0d",
               req, got_p, got_k, exp_p, exp_k);
    end
  endtask

  task automatic cfg(input logic is10, input logic ext, input logic ren,
                     input logic [7:0] own, input logic [7:0] bnd, input logic [2:0] hi);
    rx_is_10b = is10; cfg_ext_en = ext; cfg_range_en = ren;
    cfg_own_addr = own; cfg_range_bound = bnd; cfg_ext_hi = hi;
  endtask

  // Strobe one address, check the result one cycle later and the drop after it.
  task automatic probe(input string req, input logic [10:0] rx, input logic [1:0] exp_k);
    @(negedge clk);
    rx_addr = rx; addr_valid = 1'b1;
    @(negedge clk);
    addr_valid = 1'b0;
    check(req, match_kind, match_pulse, exp_k);
    @(negedge clk);
    check({req, " R10 drop"}, match_kind, match_pulse, 2'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    check("R1 in reset", match_kind, match_pulse, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", match_kind, match_pulse, 2'd0);

    // R2 exact, with and without window mode
    cfg(1'b0, 1'b0, 1'b0, 8'h20, 8'h30, 3'd0);
    probe("R2 exact range off", 11'h020, 2'd1);
    cfg(1'b0, 1'b0, 1'b1, 8'h20, 8'h30, 3'd0);
    probe("R2 exact range on", 11'h020, 2'd1);
    // R3/R4/R5 edges
    probe("R4 below own", 11'h01F, 2'd0);
    probe("R3 R4 own+1", 11'h021, 2'd2);
    probe("R3 inside", 11'h028, 2'd2);
    probe("R5 at bound", 11'h030, 2'd2);
    probe("R5 bound+1", 11'h031, 2'd0);
    // R6 window off
    cfg(1'b0, 1'b0, 1'b0, 8'h20, 8'h30, 3'd0);
    probe("R6 window off inside", 11'h025, 2'd0);
    probe("R6 window off bound", 11'h030, 2'd0);
    // R7 empty windows
    cfg(1'b0, 1'b0, 1'b1, 8'h40, 8'h30, 3'd0);
    probe("R7 inverted window", 11'h41, 2'd0);
    probe("R7 inverted window low", 11'h35, 2'd0);
    cfg(1'b0, 1'b0, 1'b1, 8'h40, 8'h40, 3'd0);
    probe("R7 bound equals own", 11'h41, 2'd0);
    probe("R7 own still exact", 11'h40, 2'd1);
    // R8 7-bit ignores bit 7, high field, rx bits 10:7
    cfg(1'b0, 1'b1, 1'b1, 8'hA0, 8'hB0, 3'd5);
    probe("R8 own bit7 ignored", 11'h020, 2'd1);
    probe("R8 rx high bits ignored", 11'h7A5, 2'd2);
    cfg(1'b0, 1'b0, 1'b1, 8'h10, 8'h90, 3'd0);
    probe("R8 bound bit7 ignored", 11'h020, 2'd0);
    // R9 10-bit with high field
    cfg(1'b1, 1'b1, 1'b0, 8'h55, 8'h00, 3'd3);
    probe("R9 ext exact", 11'h355, 2'd1);
    probe("R9 ext wrong hi", 11'h155, 2'd0);
    cfg(1'b1, 1'b0, 1'b0, 8'h55, 8'h00, 3'd3);
    probe("R9 ext off hi ignored", 11'h055, 2'd1);
    probe("R9 ext off no hi match", 11'h355, 2'd0);
    cfg(1'b1, 1'b1, 1'b1, 8'hF0, 8'h10, 3'd2);
    probe("R9 ext window", 11'h205, 2'd0);
    probe("R9 ext own+1", 11'h2F1, 2'd0);
    cfg(1'b1, 1'b1, 1'b1, 8'h10, 8'hF0, 3'd2);
    probe("R9 R3 ext inside", 11'h280, 2'd2);
    probe("R9 R5 ext bound", 11'h2F0, 2'd2);
    probe("R9 ext above bound", 11'h2F1, 2'd0);

    // R10 no strobe, matching inputs, no pulse
    cfg(1'b0, 1'b0, 1'b1, 8'h20, 8'h30, 3'd0);
    @(negedge clk); rx_addr = 11'h020;
    @(negedge clk);
    check("R10 no strobe", match_kind, match_pulse, 2'd0);

    // R10 back-to-back strobes
    @(negedge clk); rx_addr = 11'h020; addr_valid = 1'b1;
    @(negedge clk); rx_addr = 11'h025;
    check("R10 b2b first", match_kind, match_pulse, 2'd1);
    @(negedge clk); rx_addr = 11'h050;
    check("R10 b2b second", match_kind, match_pulse, 2'd2);
    @(negedge clk); addr_valid = 1'b0;
    check("R10 b2b third", match_kind, match_pulse, 2'd0);

    // Random, biased toward the window edges
    for (int i = 0; i < 400; i++) begin
      logic is10, ext, ren;
      logic [7:0] own, bnd;
      logic [2:0] hi;
      logic [10:0] rx;
      int sel;
      is10 = 1'($urandom); ext = 1'($urandom); ren = 1'($urandom);
      own = 8'($urandom); bnd = 8'($urandom); hi = 3'($urandom);
      sel = $urandom_range(0, 4);
      rx = 11'($urandom);
      if (sel == 0) rx[7:0] = own;
      if (sel == 1) rx[7:0] = own + 8'd1;
      if (sel == 2) rx[7:0] = bnd;
      if (sel == 3) rx[7:0] = bnd + 8'd1;
      if (is10 && $urandom_range(0, 1) == 1) rx[10:8] = ext ? hi : 3'd0;
      cfg(is10, ext, ren, own, bnd, hi);
      probe("R2-R9 random", rx, model_kind(is10, ext, ren, own, bnd, hi, rx));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule